// File: doc/BRIEF.md
# Synchronization Correlation Peak Validator

This block sits after a sync-sequence matched filter that runs at the reduced correlation rate. At that rate the filter produces one sample for every 16 baseband samples, so a 10 ms radio frame holds 19,200 correlation samples. The block divides the incoming stream of correlation magnitudes into windows one frame long. In each window it picks the single largest sample as the peak candidate. It accepts the candidate only if the candidate stands well clear of the window's average correlation energy.

The block does not trust a single strong peak. It follows where accepted peaks land from frame to frame and raises its lock flag only after a run of consecutive accepted peaks whose positions stay close together. When the block is locked, one frame with a missing or displaced peak clears the lock. Downstream logic reads three outputs: the lock flag, the position of the most recent accepted peak, and a pulse once per frame that marks a valid peak.

The window boundaries come from a counter of valid correlation samples. Reset restarts this counter. The average is never formed by division. The block compares the peak times the window length against the threshold ratio times the window sum.

Top module: `corr_sync_validator`

## Requirements
- R1: While reset is high and in the cycle after it, `lock` is 0, `peak_ok` is 0 and `peak_pos` is 0.
- R2: A window is exactly `WIN_LEN` samples that have `corr_vld` high. Cycles with `corr_vld` low are not counted. Reset restarts the window, so the next valid sample has index 0. The frame decision is registered at the clock edge that consumes the last sample of the window. Before that edge, `peak_ok` stays 0.
- R3: The candidate is the largest magnitude in the window. Its position is the index of that sample within the window, from 0 to `WIN_LEN-1`. When several samples share the maximum, the earliest one is kept.
- R4: A candidate is accepted only when `peak * WIN_LEN > RATIO * window_sum`, where the comparison is strict. An all-zero window is never accepted.
- R5: `peak_ok` is high for exactly one cycle after a frame decision. It is high only if the candidate is accepted and the frame does not break an existing lock.
- R6: An accepted candidate extends the run of consecutive accepted peaks when its position differs from the previous accepted position by at most `MAX_DRIFT`. Otherwise the run restarts at one, with this candidate as the new reference.
- R7: `lock` rises at the frame decision that completes `LOCK_CNT` consecutive accepted peaks. While the run continues, `lock` stays high. `lock` changes only at frame decisions.
- R8: While locked, a rejected candidate, or an accepted one that drifts more than `MAX_DRIFT`, clears `lock` and leaves `peak_ok` low for that frame.
- R9: `peak_pos` takes the candidate position at every accepted frame, including one that breaks lock. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_vld | input | 1 | Correlation sample strobe |
| corr_mag | input | MAG_W | Correlation magnitude |
| lock | output | 1 | Frame timing locked |
| peak_ok | output | 1 | One-cycle pulse: valid peak this frame |
| peak_pos | output | $clog2(WIN_LEN) | Window index of last accepted peak |

## Verification
The hardest situation to reach from the ports is the loss of lock through a displaced peak. Reaching it takes a full sequence of accepted frames that stay within drift, followed by one strong peak that lands well away from the others. The vector table puts the block through these states in order with a shortened window, so each frame costs only a few dozen cycles. Separate frames sit exactly at the acceptance threshold and one step below it. The directed tests add gapped strobes, a reset in the middle of a window, a tie for the maximum and an all-zero frame.

// File: rtl/corr_sync_pkg.sv
package corr_sync_pkg;

    typedef struct packed {
        logic accept;
        logic near;
    } verdict_t;

    function automatic logic [31:0] pos_dist(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/corr_win_timer.sv
module corr_win_timer #(
    parameter int WIN_LEN = 19200,
    parameter int POS_W   = $clog2(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    output logic [POS_W-1:0] idx,
    output logic             last
);
    localparam logic [POS_W-1:0] IDX_MAX = POS_W'(WIN_LEN - 1);

    logic [POS_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (vld) begin
            if (idx_q == IDX_MAX) idx_q <= '0;
            else                  idx_q <= idx_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign last = vld && (idx_q == IDX_MAX);
endmodule

// File: rtl/corr_win_peak.sv
module corr_win_peak #(
    parameter int MAG_W = 16,
    parameter int POS_W = 15,
    parameter int SUM_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [POS_W-1:0] idx,
    input  logic [MAG_W-1:0] mag,
    output logic [MAG_W-1:0] cand_mag,
    output logic [POS_W-1:0] cand_pos,
    output logic [SUM_W-1:0] cand_sum
);
    logic [MAG_W-1:0] max_q;
    logic [POS_W-1:0] pos_q;
    logic [SUM_W-1:0] sum_q;
    logic             first;

    assign first = (idx == '0);

    always_comb begin
        if (first || (mag > max_q)) begin
            cand_mag = mag;
            cand_pos = idx;
        end else begin
            cand_mag = max_q;
            cand_pos = pos_q;
        end
        cand_sum = first ? SUM_W'(mag) : (sum_q + SUM_W'(mag));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            max_q <= '0;
            pos_q <= '0;
            sum_q <= '0;
        end else if (vld) begin
            max_q <= cand_mag;
            pos_q <= cand_pos;
            sum_q <= cand_sum;
        end
    end
endmodule

// File: rtl/corr_lock_track.sv
module corr_lock_track
    import corr_sync_pkg::*;
#(
    parameter int WIN_LEN   = 19200,
    parameter int RATIO     = 8,
    parameter int MAX_DRIFT = 5,
    parameter int LOCK_CNT  = 3,
    parameter int MAG_W     = 16,
    parameter int POS_W     = 15,
    parameter int SUM_W     = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_last,
    input  logic [MAG_W-1:0] cand_mag,
    input  logic [POS_W-1:0] cand_pos,
    input  logic [SUM_W-1:0] cand_sum,
    output logic             lock,
    output logic             peak_ok,
    output logic [POS_W-1:0] peak_pos
);
    localparam int CMP_W = SUM_W + $clog2(RATIO + 1) + 1;
    localparam int CNT_W = $clog2(LOCK_CNT + 1);

    logic [CNT_W-1:0] streak_q;
    logic [POS_W-1:0] ref_q;
    logic             lock_q;
    logic             ok_q;
    logic [POS_W-1:0] pos_q;
    logic [CMP_W-1:0] lhs;
    logic [CMP_W-1:0] rhs;
    verdict_t         vd;

    always_comb begin
        lhs       = CMP_W'(cand_mag) * CMP_W'(WIN_LEN);
        rhs       = CMP_W'(cand_sum) * CMP_W'(RATIO);
        vd.accept = (lhs > rhs);
        vd.near   = (pos_dist(32'(cand_pos), 32'(ref_q)) <= 32'(MAX_DRIFT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            streak_q <= '0;
            ref_q    <= '0;
            lock_q   <= 1'b0;
            ok_q     <= 1'b0;
            pos_q    <= '0;
        end else if (win_last) begin
            if (!vd.accept) begin
                streak_q <= '0;
                lock_q   <= 1'b0;
                ok_q     <= 1'b0;
            end else if ((streak_q == '0) || !vd.near) begin
                streak_q <= CNT_W'(1);
                ref_q    <= cand_pos;
                pos_q    <= cand_pos;
                lock_q   <= (LOCK_CNT <= 1);
                ok_q     <= !lock_q;
            end else begin
                if (32'(streak_q) < LOCK_CNT) streak_q <= streak_q + 1'b1;
                ref_q  <= cand_pos;
                pos_q  <= cand_pos;
                lock_q <= (32'(streak_q) + 1 >= LOCK_CNT);
                ok_q   <= 1'b1;
            end
        end else begin
            ok_q <= 1'b0;
        end
    end

    assign lock     = lock_q;
    assign peak_ok  = ok_q;
    assign peak_pos = pos_q;
endmodule

// File: rtl/corr_sync_validator.sv
module corr_sync_validator #(
    parameter int WIN_LEN   = 19200,
    parameter int MAG_W     = 16,
    parameter int RATIO     = 8,
    parameter int MAX_DRIFT = 5,
    parameter int LOCK_CNT  = 3,
    localparam int POS_W    = $clog2(WIN_LEN),
    localparam int SUM_W    = MAG_W + POS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             corr_vld,
    input  logic [MAG_W-1:0] corr_mag,
    output logic             lock,
    output logic             peak_ok,
    output logic [POS_W-1:0] peak_pos
);
    logic [POS_W-1:0] win_idx;
    logic             win_last;
    logic [MAG_W-1:0] cand_mag;
    logic [POS_W-1:0] cand_pos;
    logic [SUM_W-1:0] cand_sum;

    corr_win_timer #(.WIN_LEN(WIN_LEN), .POS_W(POS_W)) timer_i (
        .clk (clk),
        .rst (rst),
        .vld (corr_vld),
        .idx (win_idx),
        .last(win_last)
    );

    corr_win_peak #(.MAG_W(MAG_W), .POS_W(POS_W), .SUM_W(SUM_W)) peak_i (
        .clk     (clk),
        .rst     (rst),
        .vld     (corr_vld),
        .idx     (win_idx),
        .mag     (corr_mag),
        .cand_mag(cand_mag),
        .cand_pos(cand_pos),
        .cand_sum(cand_sum)
    );

    corr_lock_track #(
        .WIN_LEN(WIN_LEN), .RATIO(RATIO), .MAX_DRIFT(MAX_DRIFT), .LOCK_CNT(LOCK_CNT),
        .MAG_W(MAG_W), .POS_W(POS_W), .SUM_W(SUM_W)
    ) lock_i (
        .clk     (clk),
        .rst     (rst),
        .win_last(win_last),
        .cand_mag(cand_mag),
        .cand_pos(cand_pos),
        .cand_sum(cand_sum),
        .lock    (lock),
        .peak_ok (peak_ok),
        .peak_pos(peak_pos)
    );
endmodule

// File: rtl/corr_sync_validator_chk.sv
module corr_sync_validator_chk #(
    parameter int WIN_LEN = 19200,
    parameter int POS_W   = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             win_last,
    input logic [POS_W-1:0] win_idx,
    input logic             lock,
    input logic             peak_ok,
    input logic [POS_W-1:0] peak_pos
);
    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        32'(win_idx) < WIN_LEN);

    p_ok_after_end_r5: assert property (@(posedge clk) disable iff (rst)
        peak_ok |-> $past(win_last));

    p_ok_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        peak_ok |=> !peak_ok);

    p_lock_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock) |-> $past(win_last));

    p_lock_rise_ok_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> peak_ok);

    p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(lock) |-> !peak_ok);

    p_pos_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !win_last |=> $stable(peak_pos));
endmodule

bind corr_sync_validator corr_sync_validator_chk #(.WIN_LEN(WIN_LEN), .POS_W(POS_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .win_last(win_last),
    .win_idx (win_idx),
    .lock    (lock),
    .peak_ok (peak_ok),
    .peak_pos(peak_pos)
);

// File: tb/corr_sync_validator_tb_top.sv
`timescale 1ns/1ps
module corr_sync_validator_tb_top;
    localparam int WL = 32;
    localparam int BG = 10;

    typedef struct packed {
        logic [15:0] peak;
        logic [7:0]  ppos;
        logic        ok;
        logic        lk;
        logic [7:0]  epos;
    } vec_t;

    // background 10: accept needs 3*peak > 310, so 104 accepts and 103 rejects
    localparam vec_t TABLE [12] = '{
        '{16'd200, 8'd5,  1'b1, 1'b0, 8'd5 },  // R6 run starts
        '{16'd200, 8'd10, 1'b1, 1'b0, 8'd10},  // R6 drift 5 kept
        '{16'd200, 8'd4,  1'b1, 1'b0, 8'd4 },  // R6 drift 6 restarts
        '{16'd104, 8'd4,  1'b1, 1'b0, 8'd4 },  // R4 threshold just met
        '{16'd200, 8'd9,  1'b1, 1'b1, 8'd9 },  // R7 lock on third
        '{16'd200, 8'd9,  1'b1, 1'b1, 8'd9 },  // R7 stays
        '{16'd200, 8'd20, 1'b0, 1'b0, 8'd20},  // R8 displaced peak
        '{16'd200, 8'd22, 1'b1, 1'b0, 8'd22},  // R6
        '{16'd200, 8'd24, 1'b1, 1'b1, 8'd24},  // R7 relock
        '{16'd103, 8'd24, 1'b0, 1'b0, 8'd24},  // R4/R8 just below threshold
        '{16'd150, 8'd0,  1'b1, 1'b0, 8'd0 },  // R3 first index
        '{16'd150, 8'd31, 1'b1, 1'b0, 8'd31}   // R3 last index
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        corr_vld = 1'b0;
    logic [15:0] corr_mag = '0;
    logic        lock;
    logic        peak_ok;
    logic [4:0]  peak_pos;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    corr_sync_validator #(.WIN_LEN(WL)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .corr_vld(corr_vld),
        .corr_mag(corr_mag),
        .lock    (lock),
        .peak_ok (peak_ok),
        .peak_pos(peak_pos)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; corr_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive samples [from, to) of a window; gap inserts an idle cycle after each
    task automatic drive(input int from, input int to, input int peak, input int ppos,
                         input int tie, input int bg, input bit gap);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            corr_vld = 1'b1;
            corr_mag = 16'((i == ppos || i == tie) ? peak : bg);
            if (gap) begin
                @(negedge clk);
                corr_vld = 1'b0;
            end
        end
        @(negedge clk);
        corr_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 lock", int'(lock), 0);
        check("R1 peak_ok", int'(peak_ok), 0);
        check("R1 peak_pos", int'(peak_pos), 0);

        for (int v = 0; v < 12; v++) begin
            drive(0, WL, int'(TABLE[v].peak), int'(TABLE[v].ppos), -1, BG, 1'b0);
            check($sformatf("R5 vec%0d peak_ok", v), int'(peak_ok), int'(TABLE[v].ok));
            check($sformatf("R7 vec%0d lock", v), int'(lock), int'(TABLE[v].lk));
            check($sformatf("R9 vec%0d peak_pos", v), int'(peak_pos), int'(TABLE[v].epos));
            @(negedge clk);
            check($sformatf("R5 vec%0d pulse ends", v), int'(peak_ok), 0);
        end

        // reset from a non-zero state
        do_reset();
        check("R1 lock after reset", int'(lock), 0);
        check("R1 pos after reset", int'(peak_pos), 0);

        // tie: equal maxima at 7 and 15, earliest wins
        drive(0, WL, 200, 7, 15, BG, 1'b0);
        check("R3 tie peak_ok", int'(peak_ok), 1);
        check("R3 tie earliest pos", int'(peak_pos), 7);

        // gapped strobes: only valid samples count
        drive(0, WL - 1, 200, 3, -1, BG, 1'b1);
        check("R2 no decision before last valid", int'(peak_ok), 0);
        check("R9 pos held mid window", int'(peak_pos), 7);
        drive(WL - 1, WL, 200, 3, -1, BG, 1'b0);
        check("R2 gapped decision", int'(peak_ok), 1);
        check("R6 drift 4 accepted pos", int'(peak_pos), 3);

        // reset mid-window restarts the window
        drive(0, 10, 200, 2, -1, BG, 1'b0);
        do_reset();
        drive(0, WL - 10, 200, 3, -1, BG, 1'b0);
        check("R2 window restarted by reset", int'(peak_ok), 0);
        drive(WL - 10, WL, 200, 3, -1, BG, 1'b0);
        check("R2 decision after full window", int'(peak_ok), 1);
        check("R6 run restarted after reset", int'(lock), 0);

        // all-zero window is never accepted
        drive(0, WL, 0, 0, -1, 0, 1'b0);
        check("R4 zero window rejected", int'(peak_ok), 0);
        check("R9 pos held on reject", int'(peak_pos), 3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule